// File: doc/BRIEF.md
# Linear-Table Translation Unit with Nested TLB Walk

This unit maps a virtual address to a physical address. Each request is checked first in a small, fast first-level TLB and then in a larger second-level TLB. When both levels miss and the walker is switched on, the unit works out where the page-table entry for the address lives in virtual space. The page table sits at a configurable virtual base, with one 8-byte slot per 4 KiB page. The unit then translates that entry address through the same two TLB levels, reads the entry over a plain memory read port, and stores it in both levels. It answers with the physical address, or with one of three fault codes that a software handler acts on.

The unit takes one request at a time. Software uses a fill port to install mappings after handling a fault, which includes the mapping for the page-table pages themselves. The TLBs never see memory writes, so software removes stale mappings through an invalidation port. That port can drop a single virtual page or clear everything. An invalidation that arrives while a request is in progress waits until the request finishes.

Controller states:
- `ST_IDLE` accepts a request, a fill or a deferred invalidation.
- `ST_PROBE_L1` moves to `ST_RESP` on a hit and to `ST_PROBE_L2` on a miss.
- `ST_PROBE_L2` moves to `ST_RESP` on a hit, which also refills the first level. With the walker off it moves to `ST_RESP` with a miss fault. Otherwise it moves to `ST_PTE_L1`.
- `ST_PTE_L1` and `ST_PTE_L2` look up the entry's own virtual page. A hit moves to `ST_FETCH`. A miss in `ST_PTE_L2` moves to `ST_RESP` with a translation fault.
- `ST_FETCH` holds the memory read until the data arrives, then moves to `ST_RESP`.
- `ST_RESP` presents the result for one cycle and returns to `ST_IDLE`.

Top module: `vpt_translator`

## Requirements
- R1: After reset, `req_ready` and `fill_ready` are 1, `rsp_valid` and `mem_rd_req` are 0, and both TLB levels are empty, so a first request with the walker off returns the miss fault.
- R2: A TLB hit answers with `rsp_paddr` = {stored physical page, request bits 11:0}, the stored writable bit and `rsp_fault` = 0 (no fault).
- R3: When both levels miss and `cfg_walk_en` is 0, the unit answers with `rsp_fault` = 1 (TLB miss) and issues no memory read.
- R4: With the walker on, the entry address is V2 = `cfg_pt_base` + VPN×8, where VPN is request bits 31:12. V2 is translated through the TLB, and the read is issued at {physical page of V2, V2 bits 11:0}, which is 8-byte aligned.
- R5: If V2 misses in both levels, the unit answers with `rsp_fault` = 2 (translation fault) and issues no memory read.
- R6: `mem_rd_data` is {PPN in bits 21:2, writable in bit 1, valid in bit 0}. A valid entry completes the request with fault 0. A cleared valid bit gives `rsp_fault` = 3 (page not present), installs nothing, and a repeat request walks again.
- R7: A successful walk installs the mapping in both levels, so a repeat request for that page hits without any memory read.
- R8: Each level replaces entries round-robin: 4 entries in the first level and 8 in the second. A page that hits only in the second level is answered one cycle later than a first-level hit and is copied into the first level.
- R9: An invalidation with `inv_all` = 0 removes only the page `inv_vpn` from both levels, and other pages still hit.
- R10: An invalidation with `inv_all` = 1 empties both levels.
- R11: An invalidation received during a walk takes effect after the response. If it is a full invalidation, the walk still answers correctly but its entry is not installed.
- R12: `req_ready` is 0 from the accepting edge until after the response. `rsp_valid` is a single-cycle pulse. `mem_rd_req` stays high with a stable address until `mem_rd_valid`.
- R13: A fill accepted while `fill_ready` is 1 installs the page in both levels and replaces any existing entry for the same page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_walk_en | input | 1 | Hardware walker enable |
| cfg_pt_base | input | VA_W | Virtual base of the linear page table (8-byte aligned) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | PA_W | Translated address (0 on fault) |
| rsp_writable | output | 1 | Writable bit of the mapping |
| rsp_fault | output | 2 | 0 none, 1 TLB miss, 2 translation fault, 3 not present |
| fill_valid | input | 1 | Software install request |
| fill_ready | output | 1 | Install accepted this cycle when valid |
| fill_vpn | input | VA_W-12 | Virtual page to install |
| fill_ppn | input | PA_W-12 | Physical page to install |
| fill_writable | input | 1 | Writable bit to install |
| inv_valid | input | 1 | Invalidation request (one-cycle pulse) |
| inv_all | input | 1 | 1: clear everything, 0: single page |
| inv_vpn | input | VA_W-12 | Page to invalidate |
| mem_rd_req | output | 1 | Entry read request, held until data |
| mem_rd_addr | output | PA_W | Physical address of the entry |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | PA_W-10 | Entry {PPN, writable, valid} |

## Verification
A sweep walks 32 consecutive pages through the table. Every fifth entry is marked not present, and the memory latency changes from page to page. This separates correct entry addressing and field extraction from an off-by-one slot, and separates successful installs from not-present entries that must not be cached. Nine fills into four- and eight-entry levels show whether the second level really backs the first and whether round-robin victim choice is correct; the latency difference exposes a refill that is missing. Walks whose entry page is absent show the translation fault apart from the plain miss. Invalidations are placed mid-walk to show whether they are deferred and whether a walk overlapped by a full invalidation leaves nothing behind.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
    localparam int PG_BITS = 12;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_MISS   = 2'd1,
        FLT_XLATE  = 2'd2,
        FLT_ABSENT = 2'd3
    } flt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE_L1,
        ST_PROBE_L2,
        ST_PTE_L1,
        ST_PTE_L2,
        ST_FETCH,
        ST_RESP
    } walk_state_e;
endpackage

// File: rtl/vpt_tlb.sv
module vpt_tlb #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_wr,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic             ins_wr,
    input  logic             inv_all,
    input  logic             inv_one,
    input  logic [VPN_W-1:0] inv_vpn
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] vld_q, vld_d;
    logic [ENTRIES-1:0] wr_q;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [IDX_W-1:0]   rr_q;

    logic [ENTRIES-1:0] lk_match, ins_match, inv_match;
    logic [IDX_W-1:0]   ins_idx;
    logic               ins_reuse;

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
            assign lk_match[e]  = vld_q[e] && (tag_q[e] == lk_vpn);
            assign ins_match[e] = vld_q[e] && (tag_q[e] == ins_vpn);
            assign inv_match[e] = vld_q[e] && (tag_q[e] == inv_vpn);
        end
    endgenerate

    // read side: at most one entry matches a page
    always_comb begin
        lk_hit = |lk_match;
        lk_ppn = '0;
        lk_wr  = 1'b0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (lk_match[e]) begin
                lk_ppn = ppn_q[e];
                lk_wr  = wr_q[e];
            end
        end
    end

    // victim: an existing slot for the same page, else the round-robin slot
    always_comb begin
        ins_reuse = |ins_match;
        ins_idx   = rr_q;
        for (int e = 0; e < ENTRIES; e++) begin
            if (ins_match[e]) ins_idx = IDX_W'(e);
        end
    end

    always_comb begin
        vld_d = vld_q;
        if (inv_all)      vld_d = '0;
        else if (inv_one) vld_d = vld_q & ~inv_match;
        if (ins_en)       vld_d[ins_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            rr_q  <= '0;
        end else begin
            vld_q <= vld_d;
            if (ins_en && !ins_reuse) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            tag_q[ins_idx] <= ins_vpn;
            ppn_q[ins_idx] <= ins_ppn;
            wr_q[ins_idx]  <= ins_wr;
        end
    end
endmodule

// File: rtl/vpt_flush_q.sv
module vpt_flush_q #(
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_valid,
    input  logic             inv_all,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             apply,
    output logic             pend_any,
    output logic             pend_all,
    output logic             pend_one,
    output logic [VPN_W-1:0] pend_vpn
);
    logic             all_d, one_d;
    logic [VPN_W-1:0] vpn_d;

    always_comb begin
        all_d = apply ? 1'b0 : pend_all;
        one_d = apply ? 1'b0 : pend_one;
        vpn_d = pend_vpn;
        if (inv_valid) begin
            if (inv_all) begin
                all_d = 1'b1;
            end else if (one_d && (vpn_d != inv_vpn)) begin
                // two different single pages collapse into a full clear
                all_d = 1'b1;
            end else begin
                one_d = 1'b1;
                vpn_d = inv_vpn;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_all <= 1'b0;
            pend_one <= 1'b0;
            pend_vpn <= '0;
        end else begin
            pend_all <= all_d;
            pend_one <= one_d;
            pend_vpn <= vpn_d;
        end
    end

    assign pend_any = pend_all | pend_one;
endmodule

// File: rtl/vpt_translator.sv
module vpt_translator
    import vpt_pkg::*;
#(
    parameter int VA_W       = 32,
    parameter int PA_W       = 32,
    parameter int L1_ENTRIES = 4,
    parameter int L2_ENTRIES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_walk_en,
    input  logic [VA_W-1:0]         cfg_pt_base,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [VA_W-1:0]         req_vaddr,
    output logic                    rsp_valid,
    output logic [PA_W-1:0]         rsp_paddr,
    output logic                    rsp_writable,
    output logic [1:0]              rsp_fault,
    input  logic                    fill_valid,
    output logic                    fill_ready,
    input  logic [VA_W-PG_BITS-1:0] fill_vpn,
    input  logic [PA_W-PG_BITS-1:0] fill_ppn,
    input  logic                    fill_writable,
    input  logic                    inv_valid,
    input  logic                    inv_all,
    input  logic [VA_W-PG_BITS-1:0] inv_vpn,
    output logic                    mem_rd_req,
    output logic [PA_W-1:0]         mem_rd_addr,
    input  logic                    mem_rd_valid,
    input  logic [PA_W-PG_BITS+1:0] mem_rd_data
);
    localparam int VPN_W = VA_W - PG_BITS;
    localparam int PPN_W = PA_W - PG_BITS;
    localparam int PTE_W = PPN_W + 2;
    localparam int PAD_W = PG_BITS - 3;

    walk_state_e state_q, state_d;

    logic [VA_W-1:0]  va_q;
    logic [PA_W-1:0]  pte_pa_q;
    logic [PA_W-1:0]  res_pa_q;
    logic             res_wr_q;
    flt_e             res_flt_q;

    logic [VPN_W-1:0] vpn1, vpn2, lk_vpn;
    logic [VA_W-1:0]  va2;

    logic             hit1, hit2, wr1, wr2;
    logic [PPN_W-1:0] ppn1, ppn2;

    logic             pte_v, pte_w;
    logic [PPN_W-1:0] pte_ppn;

    logic             pend_any, pend_all, pend_one;
    logic [VPN_W-1:0] pend_vpn;
    logic             apply, kill;
    logic             accept, fill_go, walk_ins, refill1;

    logic             l1_ins, l2_ins;
    logic [VPN_W-1:0] ins_vpn;
    logic [PPN_W-1:0] l1_ins_ppn, l2_ins_ppn;
    logic             l1_ins_wr, l2_ins_wr;
    logic             t_inv_all, t_inv_one;

    // address arithmetic for the linear table
    assign vpn1   = va_q[VA_W-1:PG_BITS];
    assign va2    = cfg_pt_base + {{PAD_W{1'b0}}, vpn1, 3'b000};
    assign vpn2   = va2[VA_W-1:PG_BITS];
    assign lk_vpn = (state_q == ST_PTE_L1 || state_q == ST_PTE_L2) ? vpn2 : vpn1;

    assign pte_v   = mem_rd_data[0];
    assign pte_w   = mem_rd_data[1];
    assign pte_ppn = mem_rd_data[PTE_W-1:2];

    // control strobes
    assign accept   = req_valid && req_ready;
    assign fill_go  = fill_valid && fill_ready;
    assign apply    = (state_q == ST_IDLE) && pend_any;
    assign kill     = pend_all || (inv_valid && inv_all);
    assign walk_ins = (state_q == ST_FETCH) && mem_rd_valid && pte_v && !kill;
    assign refill1  = (state_q == ST_PROBE_L2) && hit2;

    // install and invalidate steering
    always_comb begin
        l1_ins     = fill_go || walk_ins || refill1;
        l2_ins     = fill_go || walk_ins;
        ins_vpn    = fill_go ? fill_vpn : vpn1;
        l2_ins_ppn = fill_go ? fill_ppn : pte_ppn;
        l2_ins_wr  = fill_go ? fill_writable : pte_w;
        l1_ins_ppn = refill1 ? ppn2 : l2_ins_ppn;
        l1_ins_wr  = refill1 ? wr2 : l2_ins_wr;
        t_inv_all  = apply && pend_all;
        t_inv_one  = apply && pend_one && !pend_all;
    end

    vpt_tlb #(.ENTRIES(L1_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_l1 (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_hit(hit1), .lk_ppn(ppn1), .lk_wr(wr1),
        .ins_en(l1_ins), .ins_vpn(ins_vpn), .ins_ppn(l1_ins_ppn), .ins_wr(l1_ins_wr),
        .inv_all(t_inv_all), .inv_one(t_inv_one), .inv_vpn(pend_vpn)
    );

    vpt_tlb #(.ENTRIES(L2_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_l2 (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_hit(hit2), .lk_ppn(ppn2), .lk_wr(wr2),
        .ins_en(l2_ins), .ins_vpn(ins_vpn), .ins_ppn(l2_ins_ppn), .ins_wr(l2_ins_wr),
        .inv_all(t_inv_all), .inv_one(t_inv_one), .inv_vpn(pend_vpn)
    );

    vpt_flush_q #(.VPN_W(VPN_W)) u_flush (
        .clk(clk), .rst_n(rst_n),
        .inv_valid(inv_valid), .inv_all(inv_all), .inv_vpn(inv_vpn),
        .apply(apply),
        .pend_any(pend_any), .pend_all(pend_all), .pend_one(pend_one), .pend_vpn(pend_vpn)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (accept) state_d = ST_PROBE_L1;
            ST_PROBE_L1: state_d = hit1 ? ST_RESP : ST_PROBE_L2;
            ST_PROBE_L2: begin
                if (hit2 || !cfg_walk_en) state_d = ST_RESP;
                else                      state_d = ST_PTE_L1;
            end
            ST_PTE_L1:   state_d = hit1 ? ST_FETCH : ST_PTE_L2;
            ST_PTE_L2:   state_d = hit2 ? ST_FETCH : ST_RESP;
            ST_FETCH:    if (mem_rd_valid) state_d = ST_RESP;
            ST_RESP:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE) && !pend_any && !inv_valid && !fill_valid;
        fill_ready   = (state_q == ST_IDLE) && !pend_any;
        mem_rd_req   = (state_q == ST_FETCH);
        mem_rd_addr  = pte_pa_q;
        rsp_valid    = (state_q == ST_RESP);
        rsp_paddr    = res_pa_q;
        rsp_writable = res_wr_q;
        rsp_fault    = res_flt_q;
    end

    // request, entry-address and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q      <= '0;
            pte_pa_q  <= '0;
            res_pa_q  <= '0;
            res_wr_q  <= 1'b0;
            res_flt_q <= FLT_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) va_q <= req_vaddr;
                ST_PROBE_L1: if (hit1) begin
                    res_pa_q  <= {ppn1, va_q[PG_BITS-1:0]};
                    res_wr_q  <= wr1;
                    res_flt_q <= FLT_NONE;
                end
                ST_PROBE_L2: begin
                    if (hit2) begin
                        res_pa_q  <= {ppn2, va_q[PG_BITS-1:0]};
                        res_wr_q  <= wr2;
                        res_flt_q <= FLT_NONE;
                    end else if (!cfg_walk_en) begin
                        res_pa_q  <= '0;
                        res_wr_q  <= 1'b0;
                        res_flt_q <= FLT_MISS;
                    end
                end
                ST_PTE_L1: if (hit1) pte_pa_q <= {ppn1, va2[PG_BITS-1:0]};
                ST_PTE_L2: begin
                    if (hit2) begin
                        pte_pa_q <= {ppn2, va2[PG_BITS-1:0]};
                    end else begin
                        res_pa_q  <= '0;
                        res_wr_q  <= 1'b0;
                        res_flt_q <= FLT_XLATE;
                    end
                end
                ST_FETCH: if (mem_rd_valid) begin
                    if (pte_v) begin
                        res_pa_q  <= {pte_ppn, va_q[PG_BITS-1:0]};
                        res_wr_q  <= pte_w;
                        res_flt_q <= FLT_NONE;
                    end else begin
                        res_pa_q  <= '0;
                        res_wr_q  <= 1'b0;
                        res_flt_q <= FLT_ABSENT;
                    end
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vpt_translator_chk.sv
module vpt_translator_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            fill_ready,
    input logic            rsp_valid,
    input logic            mem_rd_req,
    input logic            mem_rd_valid,
    input logic [PA_W-1:0] mem_rd_addr,
    input logic            cfg_walk_en
);
    // R12
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R12
    single_rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R12
    rsp_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_rd_addr));

    // R12
    busy_blocks_ports_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready && !fill_ready);

    // R3
    no_read_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> cfg_walk_en);

    // R4
    entry_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> mem_rd_addr[2:0] == 3'b000);
endmodule

bind vpt_translator vpt_translator_chk #(.PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .fill_ready(fill_ready), .rsp_valid(rsp_valid), .mem_rd_req(mem_rd_req),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .cfg_walk_en(cfg_walk_en)
);

// File: tb/tb_vpt_translator.sv
module tb_vpt_translator;
    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] PT_PPN = 20'h00077;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_walk_en = 1'b0;
    logic [31:0] cfg_pt_base = 32'h0040_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_writable;
    logic [1:0]  rsp_fault;
    logic        fill_valid = 1'b0;
    logic        fill_ready;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_writable = 1'b0;
    logic        inv_valid = 1'b0;
    logic        inv_all = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [21:0] mem_rd_data = '0;

    int n_chk = 0, n_bad = 0;
    int mem_reads = 0, mem_lat = 0, wait_cnt = 0, cycles = 0;
    logic [31:0] last_rd_addr = '0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpt_translator dut (.*);

    function automatic logic [19:0] ppn_of(input logic [8:0] v);
        return 20'h30000 + 20'(v) * 20'd3;
    endfunction

    function automatic logic [21:0] pte_of(input logic [31:0] pa);
        logic [8:0] v;
        v = pa[11:3];
        if (pa[31:12] != PT_PPN) return '0;
        return {ppn_of(v), v[0], (v % 5) != 4};
    endfunction

    // memory model with programmable latency
    always @(negedge clk) begin
        if (mem_rd_valid) begin
            mem_rd_valid <= 1'b0;
        end else if (mem_rd_req) begin
            if (wait_cnt >= mem_lat) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= pte_of(mem_rd_addr);
                last_rd_addr = mem_rd_addr;
                mem_reads++;
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xlate(input logic [31:0] va, input int mlat, input int inj, input logic [19:0] ivpn,
                         output logic [1:0] f, output logic [31:0] pa, output logic w, output int lat);
        mem_lat = mlat;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R12 ready low while busy", 64'(req_ready), 64'd0);
        lat = 0;
        while (!rsp_valid) begin
            lat++;
            if (lat == 3 && inj != 0) begin
                inv_valid = 1'b1;
                inv_all   = (inj == 1);
                inv_vpn   = ivpn;
                @(negedge clk);
                inv_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        f  = rsp_fault;
        pa = rsp_paddr;
        w  = rsp_writable;
        @(negedge clk);
    endtask

    task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic w);
        while (!fill_ready) @(negedge clk);
        fill_valid = 1'b1;
        fill_vpn = v;
        fill_ppn = p;
        fill_writable = w;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic invalidate(input logic all, input logic [19:0] v);
        inv_valid = 1'b1;
        inv_all = all;
        inv_vpn = v;
        @(negedge clk);
        inv_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [1:0]  f;
        logic [31:0] pa;
        logic        w;
        int          lat, lat1, lat2, r0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(req_ready && fill_ready && !rsp_valid && !mem_rd_req, "R1 reset outputs",
            64'({req_ready, fill_ready, rsp_valid, mem_rd_req}), 64'b1100);
        xlate(32'h0001_0000, 0, 0, 0, f, pa, w, lat);
        chk(f == 2'd1, "R1 empty after reset", 64'(f), 64'd1);
        chk(mem_reads == 0, "R3 no read with walker off", 64'(mem_reads), 64'd0);

        // R13 / R2 fill then hit, overwrite same page
        fill(20'h00005, 20'h00123, 1'b1);
        xlate(32'h0000_5ABC, 0, 0, 0, f, pa, w, lat1);
        chk(f == 2'd0 && pa == 32'h0012_3ABC && w, "R2 hit translation", 64'(pa), 64'h0012_3ABC);
        fill(20'h00005, 20'h00456, 1'b0);
        xlate(32'h0000_5ABC, 0, 0, 0, f, pa, w, lat);
        chk(pa == 32'h0045_6ABC && !w, "R13 fill overwrites page", 64'(pa), 64'h0045_6ABC);

        // R10 clear, R8 round-robin over nine fills
        invalidate(1'b1, 0);
        xlate(32'h0000_5000, 0, 0, 0, f, pa, w, lat);
        chk(f == 2'd1, "R10 full invalidate", 64'(f), 64'd1);
        for (int i = 0; i < 9; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1'b0);
        xlate(32'h0010_0000, 0, 0, 0, f, pa, w, lat);
        chk(f == 2'd1, "R8 oldest evicted from both levels", 64'(f), 64'd1);
        xlate(32'h0010_1010, 0, 0, 0, f, pa, w, lat2);
        chk(f == 2'd0 && pa == 32'h0020_1010, "R8 second-level hit", 64'(pa), 64'h0020_1010);
        chk(lat2 == lat1 + 1, "R8 second-level latency", 64'(lat2), 64'(lat1 + 1));
        xlate(32'h0010_1010, 0, 0, 0, f, pa, w, lat);
        chk(lat == lat1, "R8 refill into first level", 64'(lat), 64'(lat1));
        xlate(32'h0010_8000, 0, 0, 0, f, pa, w, lat);
        chk(lat == lat1 && pa == 32'h0020_8000, "R8 newest in first level", 64'(pa), 64'h0020_8000);

        // R9 single-page invalidate
        invalidate(1'b0, 20'h00108);
        xlate(32'h0010_8000, 0, 0, 0, f, pa, w, lat);
        chk(f == 2'd1, "R9 page removed", 64'(f), 64'd1);
        xlate(32'h0010_7004, 0, 0, 0, f, pa, w, lat);
        chk(f == 2'd0 && pa == 32'h0020_7004, "R9 other page kept", 64'(pa), 64'h0020_7004);
        invalidate(1'b1, 0);

        // R4 R5 R6 R7 sweep of the walker
        cfg_walk_en = 1'b1;
        for (int v = 16; v < 48; v++) begin
            logic [31:0] va;
            logic [31:0] exp_pa;
            va = {20'(v), 12'((v * 37) & 12'hfff)};
            exp_pa = {ppn_of(9'(v)), va[11:0]};
            fill(20'h00400, PT_PPN, 1'b0);
            r0 = mem_reads;
            xlate(va, v % 4, 0, 0, f, pa, w, lat);
            chk(mem_reads == r0 + 1 && last_rd_addr == {PT_PPN, 12'(v * 8)}, "R4 entry address",
                64'(last_rd_addr), 64'({PT_PPN, 12'(v * 8)}));
            if (v % 5 == 4) begin
                chk(f == 2'd3, "R6 not present", 64'(f), 64'd3);
                xlate(va, 0, 0, 0, f, pa, w, lat);
                chk(f == 2'd3 && mem_reads == r0 + 2, "R6 absent entry not installed",
                    64'(mem_reads - r0), 64'd2);
            end else begin
                chk(f == 2'd0 && pa == exp_pa && w == 1'(v & 1), "R6 walk result", 64'(pa), 64'(exp_pa));
                xlate(va, 0, 0, 0, f, pa, w, lat);
                chk(pa == exp_pa && mem_reads == r0 + 1 && lat == lat1, "R7 installed after walk",
                    64'(mem_reads - r0), 64'd1);
            end
        end

        // R5 entry page not mapped
        r0 = mem_reads;
        xlate(32'h0025_0000, 0, 0, 0, f, pa, w, lat);
        chk(f == 2'd2 && mem_reads == r0, "R5 translation fault", 64'(f), 64'd2);

        // R11 full invalidate during walk
        fill(20'h00400, PT_PPN, 1'b0);
        xlate(32'h0003_2010, 6, 1, 0, f, pa, w, lat);
        chk(f == 2'd0 && pa == {ppn_of(9'h32), 12'h010}, "R11 walk completes under flush",
            64'(pa), 64'({ppn_of(9'h32), 12'h010}));
        cfg_walk_en = 1'b0;
        xlate(32'h0003_2010, 0, 0, 0, f, pa, w, lat);
        chk(f == 2'd1, "R11 result not installed", 64'(f), 64'd1);

        // R11 single invalidate deferred past the install
        cfg_walk_en = 1'b1;
        fill(20'h00400, PT_PPN, 1'b0);
        xlate(32'h0003_3000, 6, 2, 20'h00033, f, pa, w, lat);
        chk(f == 2'd0 && pa == {ppn_of(9'h33), 12'h000}, "R11 walk with pending single",
            64'(pa), 64'({ppn_of(9'h33), 12'h000}));
        cfg_walk_en = 1'b0;
        xlate(32'h0003_3000, 0, 0, 0, f, pa, w, lat);
        chk(f == 2'd1, "R11 deferred single applied", 64'(f), 64'd1);
        cfg_walk_en = 1'b1;
        xlate(32'h0003_5000, 0, 0, 0, f, pa, w, lat);
        chk(f == 2'd0 && pa == {ppn_of(9'h35), 12'h000}, "R11 table page kept",
            64'(pa), 64'({ppn_of(9'h35), 12'h000}));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule